// File: doc/BRIEF.md
# Overcurrent retry sequencer

This block decides, on every clock, whether a half-bridge may switch. It raises one enable that gates both gate drives. It also raises a status flag for a host controller whenever the bridge is held off. The inputs are an overcurrent flag, an external shutdown request, two supply-good flags, a strap that selects latched operation, and a host reset line.

A digital ramp counter stands in for an external timing capacitor. The counter has a lower and an upper threshold. After an overcurrent trip the counter ramps down. Crossing the lower threshold clears the fault latch. The counter then ramps back up, and switching resumes only once it rises past the upper threshold. The same upward ramp sets the delay after reset, after a supply dropout and after a shutdown request.

With the latched strap set, the counter is pinned at full scale, so a trip stays in force until the host reset is held long enough to pull the counter to zero. A host reset of that length is also needed once after power-up. All levels, steps and the hold time are parameters.

Top module: `ocp_retry_seq`

## Requirements
- R1: While rst_ni is low, run_en_o is 0 and sd_stat_o is 1.
- R2: In self-reset mode, with both supplies good and default unit steps, run_en_o first reads 1 after TH_HI+2 rising edges following reset release.
- R3: An overcurrent flag seen while run_en_o is 1 forces run_en_o to 0 from the next rising edge.
- R4: After a trip, the fault stays latched until the counter drops below TH_LO. After that, run_en_o returns only once the counter has climbed above TH_HI. run_en_o is 0 whenever the counter is below TH_LO.
- R5: A permanent overcurrent produces repeated short enable pulses, one per discharge and recharge cycle.
- R6: If either vdd_ok_i or vcc_ok_i is 0, run_en_o is 0 in the same cycle and the counter is cleared. After both flags return, the R2 delay applies again.
- R7: sd_req_i forces run_en_o to 0 in the same cycle and clears the counter. After release, the R2 delay applies again.
- R8: With latch_mode_i set to 1, a trip keeps run_en_o at 0 until a qualified host reset arrives. run_en_o is 1 again on the second edge after that reset is released.
- R9: With latch_mode_i set to 1, run_en_o stays 0 after power-up until the first qualified host reset.
- R10: A host reset counts as qualified only when held for more than RST_HOLD rising edges. A pulse of exactly RST_HOLD edges has no effect.
- R11: sd_stat_o is always the inverse of run_en_o.
- R12: The retry delay after a trip from full scale is longer than the power-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oc_i | input | 1 | Overcurrent detected (high side or low side) |
| sd_req_i | input | 1 | External shutdown request; clears the counter |
| vdd_ok_i | input | 1 | Logic supply above its undervoltage level |
| vcc_ok_i | input | 1 | Gate supply above its undervoltage level |
| latch_mode_i | input | 1 | 1 = latched protection, 0 = self-reset retry |
| host_rst_i | input | 1 | Host reset; acts only when held long enough |
| run_en_o | output | 1 | Enable for both gate drives |
| sd_stat_o | output | 1 | Shutdown or fault status for the host |

## Verification
Some results are combinational and are due in the cycle of the stimulus: the shutdown request and supply loss force the enable low at once. An overcurrent trip takes effect one edge after it is seen. Release after reset, after a dropout or after a shutdown request is due TH_HI+2 edges later. A latched-mode release is due two edges after a qualified reset ends. Inputs change on falling edges and outputs are read 1 ns later, which is before the next rising edge. A behavioural model advanced on each rising edge gives the expected enable for every cycle, and directed checks count edges from the stimulus to the enable edge.

// File: rtl/ocp_seq_pkg.sv
package ocp_seq_pkg;
  typedef enum logic [1:0] {
    TMR_UP   = 2'd0,
    TMR_DOWN = 2'd1,
    TMR_DUMP = 2'd2,
    TMR_FILL = 2'd3
  } tmr_cmd_e;
endpackage

// File: rtl/ocp_rst_qual.sv
module ocp_rst_qual #(
  parameter int unsigned HOLD = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic act_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= '0;
    else if (!req_i)            hold_q <= '0;
    else if (hold_q != HOLD_V)  hold_q <= hold_q + HW'(1);
  end

  // acts only from the edge after HOLD edges of continuous assertion
  assign act_o = req_i && (hold_q == HOLD_V);
endmodule

// File: rtl/ocp_ramp_timer.sv
module ocp_ramp_timer
  import ocp_seq_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned TH_LO   = 16,
  parameter int unsigned TH_HI   = 160,
  parameter int unsigned UP_STEP = 1,
  parameter int unsigned DN_STEP = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  tmr_cmd_e cmd_i,
  output logic     below_lo_o,
  output logic     above_hi_o
);
  localparam logic [CNT_W-1:0] LO_V = CNT_W'(TH_LO);
  localparam logic [CNT_W-1:0] HI_V = CNT_W'(TH_HI);
  localparam logic [CNT_W-1:0] DN_V = CNT_W'(DN_STEP);

  logic [CNT_W-1:0] cnt_q, cnt_d, up_val;

  generate
    if (UP_STEP == 1) begin : g_inc
      assign up_val = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
    end else begin : g_add
      logic [CNT_W:0] sum;
      assign sum    = {1'b0, cnt_q} + (CNT_W + 1)'(UP_STEP);
      assign up_val = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (cmd_i)
      TMR_DUMP: cnt_d = '0;
      TMR_FILL: cnt_d = '1;
      TMR_DOWN: cnt_d = (cnt_q >= DN_V) ? cnt_q - DN_V : '0;
      default:  cnt_d = up_val;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign below_lo_o = cnt_q < LO_V;
  assign above_hi_o = cnt_q > HI_V;
endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
  import ocp_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     oc_i,
  input  logic     sd_req_i,
  input  logic     sup_ok_i,
  input  logic     latch_mode_i,
  input  logic     rst_act_i,
  input  logic     below_lo_i,
  input  logic     above_hi_i,
  output tmr_cmd_e cmd_o,
  output logic     run_en_o
);
  logic fault_q, hyst_q, lock_q;

  // below_lo term blocks a one-cycle glitch after a dump while hyst_q is still set
  assign run_en_o = sup_ok_i && !sd_req_i && hyst_q && !fault_q && !below_lo_i
                    && !(latch_mode_i && lock_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      hyst_q  <= 1'b0;
      lock_q  <= 1'b1;
    end else begin
      if (oc_i && run_en_o) fault_q <= 1'b1;
      else if (below_lo_i)  fault_q <= 1'b0;
      if (above_hi_i)       hyst_q  <= 1'b1;
      else if (below_lo_i)  hyst_q  <= 1'b0;
      if (rst_act_i)        lock_q  <= 1'b0;
    end
  end

  always_comb begin
    if (!sup_ok_i || sd_req_i || rst_act_i) cmd_o = TMR_DUMP;
    else if (latch_mode_i)                  cmd_o = TMR_FILL;
    else if (fault_q)                       cmd_o = TMR_DOWN;
    else                                    cmd_o = TMR_UP;
  end
endmodule

// File: rtl/ocp_retry_seq.sv
module ocp_retry_seq
  import ocp_seq_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned TH_LO    = 16,
  parameter int unsigned TH_HI    = 160,
  parameter int unsigned UP_STEP  = 1,
  parameter int unsigned DN_STEP  = 1,
  parameter int unsigned RST_HOLD = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic sd_req_i,
  input  logic vdd_ok_i,
  input  logic vcc_ok_i,
  input  logic latch_mode_i,
  input  logic host_rst_i,
  output logic run_en_o,
  output logic sd_stat_o
);
  tmr_cmd_e tmr_cmd;
  logic     tmr_below_lo, tmr_above_hi, rst_act, run_en;

  ocp_rst_qual #(.HOLD(RST_HOLD)) u_rst_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (host_rst_i),
    .act_o  (rst_act)
  );

  ocp_ramp_timer #(
    .CNT_W(CNT_W), .TH_LO(TH_LO), .TH_HI(TH_HI),
    .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (tmr_cmd),
    .below_lo_o (tmr_below_lo),
    .above_hi_o (tmr_above_hi)
  );

  ocp_fault_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oc_i         (oc_i),
    .sd_req_i     (sd_req_i),
    .sup_ok_i     (vdd_ok_i && vcc_ok_i),
    .latch_mode_i (latch_mode_i),
    .rst_act_i    (rst_act),
    .below_lo_i   (tmr_below_lo),
    .above_hi_i   (tmr_above_hi),
    .cmd_o        (tmr_cmd),
    .run_en_o     (run_en)
  );

  assign run_en_o  = run_en;
  assign sd_stat_o = ~run_en;
endmodule

// File: rtl/ocp_retry_seq_chk.sv
module ocp_retry_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic oc_i,
  input logic sd_req_i,
  input logic vdd_ok_i,
  input logic vcc_ok_i,
  input logic run_en_o,
  input logic sd_stat_o,
  input logic above_hi
);
  AST_RESET_OFF: assert property (@(posedge clk_i) !rst_ni |-> !run_en_o && sd_stat_o); // R1

  AST_OC_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_o && oc_i |=> !run_en_o); // R3

  AST_RESUME_ABOVE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_en_o) |-> above_hi); // R4

  AST_SUPPLY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vdd_ok_i && vcc_ok_i) |-> !run_en_o); // R6

  AST_SD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_req_i |-> !run_en_o); // R7

  AST_STAT_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_stat_o != run_en_o); // R11
endmodule

bind ocp_retry_seq ocp_retry_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oc_i      (oc_i),
  .sd_req_i  (sd_req_i),
  .vdd_ok_i  (vdd_ok_i),
  .vcc_ok_i  (vcc_ok_i),
  .run_en_o  (run_en_o),
  .sd_stat_o (sd_stat_o),
  .above_hi  (tmr_above_hi)
);

// File: tb/ocp_retry_seq_bench.sv
`timescale 1ns/1ps
module ocp_retry_seq_bench;
  localparam int CNT_W = 8, TH_LO = 16, TH_HI = 160, UP = 1, DN = 1, HOLD = 40;
  localparam int FULL = (1 << CNT_W) - 1;
  localparam int T_SU = TH_HI + 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic oc_i = 0, sd_req_i = 0, vdd_ok_i = 1, vcc_ok_i = 1, latch_mode_i = 0, host_rst_i = 0;
  logic run_en_o, sd_stat_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ocp_retry_seq #(
    .CNT_W(CNT_W), .TH_LO(TH_LO), .TH_HI(TH_HI),
    .UP_STEP(UP), .DN_STEP(DN), .RST_HOLD(HOLD)
  ) u_ocp_retry_seq (.*);

  // reference model
  int m_cnt, m_rh;
  bit m_fault, m_hyst, m_lock;

  function automatic bit exp_run();
    return vdd_ok_i && vcc_ok_i && !sd_req_i && m_hyst && !m_fault
           && (m_cnt >= TH_LO) && !(latch_mode_i && m_lock);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_fault = 0; m_hyst = 0; m_lock = 1; m_rh = 0;
    end else begin
      bit r, act, lo, hi, nf, nh;
      r   = exp_run();
      act = host_rst_i && (m_rh == HOLD);
      lo  = m_cnt < TH_LO;
      hi  = m_cnt > TH_HI;
      nf  = (oc_i && r) ? 1'b1 : (lo ? 1'b0 : m_fault);
      nh  = hi ? 1'b1 : (lo ? 1'b0 : m_hyst);
      if (act) m_lock = 0;
      if (!(vdd_ok_i && vcc_ok_i) || sd_req_i || act) m_cnt = 0;
      else if (latch_mode_i) m_cnt = FULL;
      else if (m_fault) m_cnt = (m_cnt >= DN) ? m_cnt - DN : 0;
      else m_cnt = (m_cnt + UP > FULL) ? FULL : m_cnt + UP;
      m_fault = nf; m_hyst = nh;
      if (!host_rst_i) m_rh = 0; else if (m_rh < HOLD) m_rh++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      chk(run_en_o == exp_run(), "R4 model run_en", int'(run_en_o), int'(exp_run()));
      chk(sd_stat_o == !run_en_o, "R11 status", int'(sd_stat_o), int'(!run_en_o));
    end
  end

  // from a falling edge just after a drive: count edges until run_en_o is 1
  task automatic wait_run(input int lim, output int k);
    #1; k = 0;
    while (!run_en_o && k < lim) begin
      @(negedge clk_i); #1; k++;
    end
  endtask

  task automatic stay_off(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #1;
      if (run_en_o) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic host_pulse(input int edges);
    @(negedge clk_i); host_rst_i = 1;
    repeat (edges) @(negedge clk_i);
    host_rst_i = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    int k, rises;
    bit prev;
    repeat (3) @(negedge clk_i);
    #1;
    chk(!run_en_o && sd_stat_o, "R1 reset state", int'(run_en_o), 0);

    @(negedge clk_i); rst_ni = 1;
    wait_run(2000, k);
    chk(k == T_SU, "R2 startup delay", k, T_SU);

    repeat (300) @(negedge clk_i);
    oc_i = 1; @(negedge clk_i); oc_i = 0; #1;
    chk(!run_en_o, "R3 trip", int'(run_en_o), 0);
    wait_run(2000, k);
    chk(k > T_SU, "R12 retry longer than startup", k, T_SU + 1);
    chk(run_en_o, "R4 resumes after recharge", int'(run_en_o), 1);

    @(negedge clk_i); oc_i = 1; rises = 0; prev = run_en_o;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk_i); #1;
      if (run_en_o && !prev) rises++;
      prev = run_en_o;
    end
    chk(rises >= 2, "R5 repeated retries", rises, 2);
    @(negedge clk_i); oc_i = 0;
    wait_run(2000, k);

    repeat (20) @(negedge clk_i);
    vcc_ok_i = 0; #1;
    chk(!run_en_o, "R6 vcc loss immediate", int'(run_en_o), 0);
    repeat (3) @(negedge clk_i);
    vcc_ok_i = 1;
    wait_run(2000, k);
    chk(k == T_SU, "R6 vcc restart delay", k, T_SU);
    @(negedge clk_i); vdd_ok_i = 0; #1;
    chk(!run_en_o, "R6 vdd loss immediate", int'(run_en_o), 0);
    repeat (3) @(negedge clk_i);
    vdd_ok_i = 1;
    wait_run(2000, k);
    chk(k == T_SU, "R6 vdd restart delay", k, T_SU);

    @(negedge clk_i); sd_req_i = 1; #1;
    chk(!run_en_o, "R7 shutdown immediate", int'(run_en_o), 0);
    repeat (5) @(negedge clk_i);
    sd_req_i = 0;
    wait_run(2000, k);
    chk(k == T_SU, "R7 release delay", k, T_SU);

    // latched mode entered at run time: held off until a qualified reset
    @(negedge clk_i); latch_mode_i = 1;
    stay_off(100, "R9 latched needs reset");
    host_pulse(HOLD + 5);
    wait_run(20, k);
    chk(k == 2, "R8 release after qualified reset", k, 2);

    repeat (10) @(negedge clk_i);
    oc_i = 1; @(negedge clk_i); oc_i = 0;
    stay_off(500, "R8 latched trip holds");
    host_pulse(HOLD);
    stay_off(100, "R10 short reset ignored");
    host_pulse(HOLD + 1);
    wait_run(20, k);
    chk(k == 2, "R10 qualified reset releases", k, 2);

    @(negedge clk_i); rst_ni = 0; #1;
    chk(sd_stat_o && !run_en_o, "R1 reset mid-run", int'(run_en_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    stay_off(400, "R9 latched power-up off");
    host_pulse(HOLD + 3);
    wait_run(20, k);
    chk(k == 2, "R9 release after reset", k, 2);

    repeat (5) @(negedge clk_i);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-run actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule